// File: doc/BRIEF.md
# Interpolating I/Q Rebuilder

This block rebuilds a real intermediate-frequency sample stream from a slow stream of I/Q pairs that arrive from network payloads. Each pair is due once every N clocks, where N is a power of two chosen at run time. Between due points the block interpolates I and Q linearly, which brings both channels back to one value per clock. It mixes the I channel with a cosine and the Q channel with a sine, and forms the output as I·cos − Q·sin. The cosine and sine come from a phase-accumulator oscillator built the same way as the one in the transmit downconverter.

The oscillator accepts a phase increment word. A load input can force the phase to a known value so that the receive phase can be aligned with the transmit side. If no new pair has arrived by a due point, the block keeps the previous pair and raises an underrun strobe for one clock. The combined result is clipped to the output width; it never wraps.

Top module: `iqup_rebuild`

## Requirements
- R1: While `rst` is high, and in the first clock after it falls, `smp_out` is 0 and `underrun` is 0.
- R2: With N = 2^`ratio_log2` (0 ≤ `ratio_log2` ≤ MAXK), a due point occurs every N clocks. After a due point that moves a channel from value a to value b, the channel takes the values a + floor(j·(b−a)/N) for j = 0..N−1 on successive clocks, and then b.
- R3: The oscillator phase is a PW-bit accumulator that adds `ph_inc` on every clock. Its top LA bits address a one-period wave table. Sine reads the addressed entry and cosine reads the entry a quarter period (2^(LA−2) entries) further on.
- R4: Table entry a (0 ≤ a < 2^LA, H = 2^(LA−1), h = a mod H, u = h·(H−h)) holds floor(AMP·16·u / (5·H² − 4·u)). The entry is negated for a ≥ H. AMP = 2^(CW−1) − 1.
- R5: `smp_out` equals floor((I·cos − Q·sin) / 2^(CW−1)), using the interpolated I and Q.
- R6: When that value lies outside the signed OW-bit range, `smp_out` is clipped to 2^(OW−1)−1 or to −2^(OW−1).
- R7: At a due point with no pair available, the previous pair is reused, so the output stays flat. `underrun` is high for exactly one clock.
- R8: While `ph_load` is high, the phase takes `ph_val` and `ph_inc` has no effect in that clock.
- R9: A pair on `in_valid` during the clock of a due point is used at that due point, and no underrun occurs. If several pairs arrive before one due point, only the last of them is used.
- R10: With `ratio_log2` unchanged, successive underrun strobes are a multiple of N clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking a new I/Q pair |
| in_i | input | DW | In-phase sample, signed |
| in_q | input | DW | Quadrature sample, signed |
| ph_inc | input | PW | Oscillator phase increment per clock |
| ph_load | input | 1 | Force oscillator phase to `ph_val` |
| ph_val | input | PW | Phase value to load |
| ratio_log2 | input | KW | log2 of the interpolation factor N |
| smp_out | output | OW | Rebuilt real sample, signed |
| underrun | output | 1 | One-clock strobe for a missed pair |

## Verification
On every clock the assertions check the underrun strobe: it lasts one clock, it never follows a clock that carried a pair, and, while the ratio is unchanged, it stays on the N-clock grid of due points. They also check that a clipped output was produced only by an out-of-range mixer result. Only the bench scenarios can show the numeric behaviour. These scenarios cover the interpolation ramp, the quarter-turn sequence of the mixed output, the wave-table values, phase loading over a running increment, last-pair-wins selection, and the flat output during starvation.

// File: rtl/iqup_pkg.sv
package iqup_pkg;

    localparam int IQW_DEF  = 12;
    localparam int CW_DEF   = 12;
    localparam int OW_DEF   = 12;
    localparam int PW_DEF   = 16;
    localparam int LA_DEF   = 6;
    localparam int MAXK_DEF = 4;

    // What happens to the pair path in a given clock
    typedef enum logic [1:0] {
        SEG_RUN  = 2'd0,
        SEG_TAKE = 2'd1,
        SEG_HOLD = 2'd2
    } seg_ev_t;

    // Rational sine approximation, one full period over 2**la entries
    function automatic int wave_pt(int a, int la, int amp);
        longint half, h, u, v;
        half = longint'(1) << (la - 1);
        h    = longint'(a) % half;
        u    = h * (half - h);
        v    = (longint'(amp) * 16 * u) / (5 * half * half - 4 * u);
        return (longint'(a) >= half) ? int'(-v) : int'(v);
    endfunction

endpackage

// File: rtl/iqup_nco.sv
module iqup_nco #(
    parameter int PW = 16,
    parameter int LA = 6,
    parameter int CW = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PW-1:0]        inc,
    input  logic                 load,
    input  logic [PW-1:0]        load_val,
    output logic signed [CW-1:0] cos_o,
    output logic signed [CW-1:0] sin_o
);
    localparam int TN  = 1 << LA;
    localparam int QTR = TN / 4;
    localparam int AMP = (1 << (CW - 1)) - 1;

    logic signed [CW-1:0] tbl [TN];
    logic [PW-1:0]        ph;
    logic [LA-1:0]        s_addr;
    logic [LA-1:0]        c_addr;

    for (genvar g = 0; g < TN; g++) begin : g_tbl
        assign tbl[g] = CW'(iqup_pkg::wave_pt(g, LA, AMP));
    end

    assign s_addr = ph[PW-1 -: LA];
    assign c_addr = s_addr + LA'(QTR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= '0;
            cos_o <= '0;
            sin_o <= '0;
        end else begin
            ph    <= load ? load_val : ph + inc;
            cos_o <= tbl[c_addr];
            sin_o <= tbl[s_addr];
        end
    end

endmodule

// File: rtl/iqup_interp.sv
module iqup_interp #(
    parameter int DW   = 12,
    parameter int MAXK = 4,
    parameter int KW   = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [KW-1:0]        k,
    input  logic signed [DW-1:0] nxt,
    output logic signed [DW-1:0] smp
);
    localparam int AW = DW + MAXK + 1;

    logic signed [DW-1:0] curr;
    logic signed [DW:0]   step;
    logic signed [AW-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            curr <= '0;
            step <= '0;
            acc  <= '0;
        end else if (load) begin
            step <= (DW+1)'(nxt) - (DW+1)'(curr);
            acc  <= AW'(curr) <<< k;
            curr <= nxt;
        end else begin
            acc  <= acc + AW'(step);
        end
    end

    assign smp = DW'(acc >>> k);

endmodule

// File: rtl/iqup_mixsum.sv
module iqup_mixsum #(
    parameter int DW = 12,
    parameter int CW = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [DW-1:0]    a_i,
    input  logic signed [DW-1:0]    a_q,
    input  logic signed [CW-1:0]    c,
    input  logic signed [CW-1:0]    s,
    output logic signed [DW+CW:0]   mix
);
    localparam int PW2 = DW + CW;

    logic signed [PW2-1:0] p_i;
    logic signed [PW2-1:0] p_q;
    logic signed [PW2:0]   diff;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_i <= '0;
            p_q <= '0;
        end else begin
            p_i <= PW2'(a_i) * PW2'(c);
            p_q <= PW2'(a_q) * PW2'(s);
        end
    end

    assign diff = (PW2+1)'(p_i) - (PW2+1)'(p_q);
    assign mix  = diff >>> (CW - 1);

endmodule

// File: rtl/iqup_rebuild.sv
module iqup_rebuild #(
    parameter int DW   = iqup_pkg::IQW_DEF,
    parameter int CW   = iqup_pkg::CW_DEF,
    parameter int OW   = iqup_pkg::OW_DEF,
    parameter int PW   = iqup_pkg::PW_DEF,
    parameter int LA   = iqup_pkg::LA_DEF,
    parameter int MAXK = iqup_pkg::MAXK_DEF,
    localparam int KW  = $clog2(MAXK + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic [PW-1:0]        ph_inc,
    input  logic                 ph_load,
    input  logic [PW-1:0]        ph_val,
    input  logic [KW-1:0]        ratio_log2,
    output logic signed [OW-1:0] smp_out,
    output logic                 underrun
);
    import iqup_pkg::*;

    localparam int MW = DW + CW + 1;
    localparam logic signed [MW-1:0] HI = MW'((2 ** (OW - 1)) - 1);
    localparam logic signed [MW-1:0] LO = MW'(-(2 ** (OW - 1)));

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } pair_t;

    pair_t                pend, last, nxt, in_pair;
    logic                 pend_v;
    logic [MAXK-1:0]      cnt;
    logic [MAXK:0]        nfull;
    logic [KW-1:0]        k_eff;
    logic                 seg_end;
    seg_ev_t              ev;
    logic signed [DW-1:0] ch_nxt [2];
    logic signed [DW-1:0] ch_smp [2];
    logic signed [CW-1:0] osc_c, osc_s;
    logic signed [MW-1:0] mix;
    logic signed [OW-1:0] smp_n;

    assign in_pair = '{re: in_i, im: in_q};
    assign k_eff   = (ratio_log2 > KW'(MAXK)) ? KW'(MAXK) : ratio_log2;
    assign nfull   = (MAXK+1)'(1) << k_eff;
    assign seg_end = {1'b0, cnt} >= (nfull - 1'b1);

    always_comb begin
        if (!seg_end)               ev = SEG_RUN;
        else if (in_valid || pend_v) ev = SEG_TAKE;
        else                        ev = SEG_HOLD;
    end

    always_comb begin
        nxt = last;
        if (ev == SEG_TAKE) nxt = in_valid ? in_pair : pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            pend     <= '0;
            pend_v   <= 1'b0;
            last     <= '0;
            underrun <= 1'b0;
        end else begin
            cnt      <= seg_end ? '0 : cnt + 1'b1;
            underrun <= (ev == SEG_HOLD);
            if (ev != SEG_RUN) begin
                last   <= nxt;
                pend_v <= 1'b0;
            end else if (in_valid) begin
                pend   <= in_pair;
                pend_v <= 1'b1;
            end
        end
    end

    assign ch_nxt[0] = nxt.re;
    assign ch_nxt[1] = nxt.im;

    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        iqup_interp #(.DW(DW), .MAXK(MAXK), .KW(KW)) u_interp (
            .clk  (clk),
            .rst  (rst),
            .load (seg_end),
            .k    (k_eff),
            .nxt  (ch_nxt[ch]),
            .smp  (ch_smp[ch])
        );
    end

    iqup_nco #(.PW(PW), .LA(LA), .CW(CW)) u_nco (
        .clk      (clk),
        .rst      (rst),
        .inc      (ph_inc),
        .load     (ph_load),
        .load_val (ph_val),
        .cos_o    (osc_c),
        .sin_o    (osc_s)
    );

    iqup_mixsum #(.DW(DW), .CW(CW)) u_mix (
        .clk (clk),
        .rst (rst),
        .a_i (ch_smp[0]),
        .a_q (ch_smp[1]),
        .c   (osc_c),
        .s   (osc_s),
        .mix (mix)
    );

    always_comb begin
        if (mix > HI)      smp_n = OW'(HI);
        else if (mix < LO) smp_n = OW'(LO);
        else               smp_n = OW'(mix);
    end

    always_ff @(posedge clk) begin
        if (rst) smp_out <= '0;
        else     smp_out <= smp_n;
    end

endmodule

// File: rtl/iqup_rebuild_chk.sv
module iqup_rebuild_chk #(
    parameter int OW   = 12,
    parameter int MW   = 25,
    parameter int KW   = 3,
    parameter int MAXK = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [KW-1:0]        ratio_log2,
    input logic                 underrun,
    input logic signed [OW-1:0] smp_out,
    input logic signed [MW-1:0] mix
);
    localparam logic signed [OW-1:0] OHI = OW'((2 ** (OW - 1)) - 1);
    localparam logic signed [OW-1:0] OLO = OW'(-(2 ** (OW - 1)));

    logic [15:0]   gap;
    logic          seen;
    logic [KW-1:0] prev_k;
    logic [KW-1:0] kk;
    logic [15:0]   msk;

    assign kk  = (ratio_log2 > KW'(MAXK)) ? KW'(MAXK) : ratio_log2;
    assign msk = (16'd1 << kk) - 16'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap    <= '0;
            seen   <= 1'b0;
            prev_k <= ratio_log2;
        end else begin
            prev_k <= ratio_log2;
            if (underrun) begin
                gap  <= '0;
                seen <= 1'b1;
            end else begin
                gap  <= gap + 16'd1;
            end
            if (ratio_log2 != prev_k) seen <= 1'b0;
        end
    end

    AST_UNDERRUN_SOLO: assert property (@(posedge clk) disable iff (rst)
        (underrun && ratio_log2 != '0) |=> (!underrun || !$stable(ratio_log2))); // R7

    AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        underrun |-> !$past(in_valid)); // R9

    AST_SAT_HI: assert property (@(posedge clk) disable iff (rst)
        (smp_out == OHI) |-> ($past(mix) >= MW'(OHI))); // R6

    AST_SAT_LO: assert property (@(posedge clk) disable iff (rst)
        (smp_out == OLO) |-> ($past(mix) <= MW'(OLO))); // R6

    AST_UNDERRUN_GRID: assert property (@(posedge clk) disable iff (rst)
        (underrun && seen && ratio_log2 == prev_k) |-> (((gap + 16'd1) & msk) == 16'd0)); // R10

endmodule

bind iqup_rebuild iqup_rebuild_chk #(
    .OW(OW), .MW(DW + CW + 1), .KW(KW), .MAXK(MAXK)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .ratio_log2 (ratio_log2),
    .underrun   (underrun),
    .smp_out    (smp_out),
    .mix        (mix)
);

// File: tb/sim_iqup_rebuild.sv
module sim_iqup_rebuild;

    localparam int DW = 12;
    localparam int CW = 12;
    localparam int OW = 12;
    localparam int PW = 16;
    localparam int LA = 6;
    localparam int AMP = 2047;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_i = '0;
    logic signed [DW-1:0] in_q = '0;
    logic [PW-1:0]        ph_inc = '0;
    logic                 ph_load = 1'b0;
    logic [PW-1:0]        ph_val = '0;
    logic [2:0]           ratio_log2 = '0;
    logic signed [OW-1:0] smp_out;
    logic                 underrun;

    int nchk = 0;
    int nbad = 0;
    bit done = 0;
    int obs_out [0:255];
    bit obs_ur  [0:255];

    always #5 clk = ~clk;

    iqup_rebuild u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .ph_inc(ph_inc), .ph_load(ph_load), .ph_val(ph_val),
        .ratio_log2(ratio_log2), .smp_out(smp_out), .underrun(underrun)
    );

    task automatic check(bit ok, string req, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wave(int a);
        longint half, h, u, v;
        half = 32;
        h = a % half;
        u = h * (half - h);
        v = (longint'(AMP) * 16 * u) / (5 * half * half - 4 * u);
        return (a >= 32) ? int'(-v) : int'(v);
    endfunction

    function automatic int expv(int vi, int vq, int c, int s);
        longint x;
        x = (longint'(vi) * c - longint'(vq) * s) >>> (CW - 1);
        if (x > 2047) x = 2047;
        if (x < -2048) x = -2048;
        return int'(x);
    endfunction

    task automatic start(int k, int inc);
        rst = 1'b1; in_valid = 1'b0; ph_load = 1'b0;
        ratio_log2 = 3'(k); ph_inc = PW'(inc);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(int vi, int vq, int cycles, int n);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            obs_out[c] = int'(smp_out);
            obs_ur[c]  = underrun;
            in_valid = (c % n == 0);
            in_i = DW'(vi);
            in_q = DW'(vq);
        end
    endtask

    task automatic idle(int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
            obs_out[c] = int'(smp_out);
            obs_ur[c]  = underrun;
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(smp_out == 0, "R1 out in reset", smp_out, 0);
        check(underrun == 0, "R1 underrun in reset", underrun, 0);
        rst = 1'b0;
        @(negedge clk);
        check(smp_out == 0, "R1 out after reset", smp_out, 0);
    endtask

    task automatic t_const();
        int urs = 0;
        start(2, 0);
        run(1000, 300, 60, 4);
        for (int c = 0; c < 60; c++) urs += obs_ur[c];
        check(urs == 0, "R9 no underrun with steady pairs", urs, 0);
        check(obs_out[59] == expv(1000, 300, AMP, 0), "R5 steady combine",
              obs_out[59], expv(1000, 300, AMP, 0));
        check(obs_out[55] == obs_out[59], "R2 steady channel", obs_out[55], obs_out[59]);
    endtask

    task automatic t_ramp();
        int t = -1;
        start(3, 0);
        run(0, 0, 40, 8);
        run(800, 0, 80, 8);
        for (int c = 0; c < 80; c++) if (t < 0 && obs_out[c] != 0) t = c;
        check(t >= 0 && t < 60, "R2 ramp start found", t, 0);
        if (t >= 0 && t < 60) begin
            for (int j = 1; j <= 8; j++)
                check(obs_out[t+j-1] == expv(100 * j, 0, AMP, 0), "R2 ramp step",
                      obs_out[t+j-1], expv(100 * j, 0, AMP, 0));
            check(obs_out[t+11] == expv(800, 0, AMP, 0), "R2 ramp end",
                  obs_out[t+11], expv(800, 0, AMP, 0));
        end
    endtask

    task automatic t_quad();
        int e [4];
        int t = -1;
        e[0] = expv(1000, 600, AMP, 0);
        e[1] = expv(1000, 600, 0, AMP);
        e[2] = expv(1000, 600, -AMP, 0);
        e[3] = expv(1000, 600, 0, -AMP);
        start(2, 16'h4000);
        run(1000, 600, 60, 4);
        for (int c = 20; c < 50; c++) if (t < 0 && obs_out[c] == e[0]) t = c;
        check(t >= 0, "R3 quarter-turn sequence found", t, e[0]);
        if (t >= 0)
            for (int m = 1; m < 8; m++)
                check(obs_out[t+m] == e[m % 4], "R3 R5 quarter-turn sequence",
                      obs_out[t+m], e[m % 4]);
    endtask

    task automatic t_load();
        int ev;
        start(2, 16'h1234);
        ph_load = 1'b1;
        ph_val  = 16'h8000;
        run(1000, 600, 40, 4);
        ev = expv(1000, 600, -AMP, 0);
        check(obs_out[39] == ev && obs_out[35] == ev, "R8 load overrides increment",
              obs_out[39], ev);
        ph_inc = '0;
        ph_val = 16'h4000;
        run(1000, 600, 4, 4);
        ph_load = 1'b0;
        run(1000, 600, 20, 4);
        ev = expv(1000, 600, 0, AMP);
        check(obs_out[19] == ev && obs_out[12] == ev, "R8 loaded phase held",
              obs_out[19], ev);
    endtask

    task automatic t_sat();
        int cv, sv, ev;
        cv = wave(24);
        sv = wave(8);
        start(2, 0);
        ph_load = 1'b1;
        ph_val  = 16'h2000;
        run(100, 0, 40, 4);
        ev = expv(100, 0, cv, sv);
        check(obs_out[39] == ev, "R4 table at eighth turn", obs_out[39], ev);
        run(2047, -2048, 40, 4);
        check(obs_out[39] == 2047, "R6 clip high", obs_out[39], 2047);
        run(-2048, 2047, 40, 4);
        check(obs_out[39] == -2048, "R6 clip low", obs_out[39], -2048);
        ph_load = 1'b0;
    endtask

    task automatic t_underrun();
        int urs = 0, prev = -1, badgap = 0, flat = 0, ev;
        start(2, 0);
        run(500, 0, 40, 4);
        for (int c = 0; c < 40; c++) urs += obs_ur[c];
        check(urs == 0, "R9 no underrun while fed", urs, 0);
        idle(40);
        urs = 0;
        ev = expv(500, 0, AMP, 0);
        for (int c = 0; c < 40; c++) begin
            if (obs_ur[c]) begin
                urs++;
                if (prev >= 0 && c - prev != 4) badgap++;
                prev = c;
            end
            if (obs_out[c] != ev) flat++;
        end
        check(urs == 10, "R7 one strobe per due point", urs, 10);
        check(badgap == 0, "R10 strobe spacing", badgap, 0);
        check(flat == 0, "R7 output held flat", flat, 0);
    endtask

    task automatic wait_ur();
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
            if (underrun) break;
        end
    endtask

    task automatic t_latest();
        start(3, 0);
        wait_ur();
        in_valid = 1'b1; in_i = 12'sd500; in_q = '0;
        @(negedge clk);
        in_i = 12'sd900;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
        check(underrun == 0, "R9 pair in window avoids underrun", underrun, 0);
        idle(50);
        check(obs_out[49] == expv(900, 0, AMP, 0), "R9 last pair wins",
              obs_out[49], expv(900, 0, AMP, 0));
        wait_ur();
        repeat (7) @(negedge clk);
        in_valid = 1'b1; in_i = 12'sd300;
        @(negedge clk);
        in_valid = 1'b0;
        check(underrun == 0, "R9 pair on due clock used", underrun, 0);
        idle(40);
        check(obs_out[39] == expv(300, 0, AMP, 0), "R9 due-clock pair value",
              obs_out[39], expv(300, 0, AMP, 0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_const();
        t_ramp();
        t_quad();
        t_load();
        t_sat();
        t_underrun();
        t_latest();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

endmodule